// File: doc/BRIEF.md
# Local-History Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a table of entries selected by low address bits of the branch. Each entry keeps a short shift register of that branch's own recent outcomes, plus a bank of 2-bit saturating counters with one counter for every possible history value. A lookup reads the entry chosen by the fetch address, uses the stored history to pick one counter, and returns that counter's top bit as the prediction in the same cycle.

Once the branch resolves, the update port trains the counter chosen by the entry's stored history and then shifts the outcome into that history. Because the history selects the counter, a single branch can learn repeating patterns such as two not-taken outcomes followed by two taken ones. The table has no tags, so branches whose index bits match share one entry. History is not updated speculatively, so no repair is needed.

Top module: `lhp_predictor`

## Requirements
- R1: The entry index is PC[IDX_W+1:2]. Bits 1:0 and bits above IDX_W+1 do not affect which entry is used. The prediction is a combinational function of lookup_pc_i and the stored state.
- R2: After reset every history is all zeros and every counter holds 1, so every lookup predicts not taken (pred_taken_o = 0).
- R3: The prediction is 1 (taken) when the selected counter is 2 or 3, and 0 (not taken) when it is 0 or 1.
- R4: An update with upd_taken_i = 1 raises the selected counter by one and stops at 3.
- R5: An update with upd_taken_i = 0 lowers the selected counter by one and stops at 0.
- R6: An update trains only the counter selected by the entry's stored history as it stands before that update. The change is visible on lookups from the clock edge that captures the update.
- R7: After training, the outcome (1 = taken) enters the entry's history as bit 0. The older bits move up one place and the oldest bit is dropped.
- R8: An update changes only the entry at upd_pc_i[IDX_W+1:2]. Two addresses with equal index bits share one entry.
- R9: If a lookup and an update address the same entry in one cycle, the lookup returns the value from before the update.
- R10: With HIST_W >= 2, a branch that repeats not-taken, not-taken, taken, taken is predicted without error once it has been trained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lookup_pc_i | input | PC_W | Fetch address to predict |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| upd_valid_i | input | 1 | Resolved branch update strobe |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |

## Verification
pred_taken_o is combinational, so the bench drives lookup_pc_i on the falling edge and samples the prediction 2 ns later, inside the same cycle. An update takes effect at the next rising edge, so its effect is first due on the lookup made at the following falling edge. The bench samples only there. The same-cycle check (R9) samples before that rising edge and expects the old value. A reference model of history and counters, updated only after each rising edge, supplies the expected value for every step.

// File: rtl/lhp_pkg.sv
package lhp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'd1;  // weakly not taken
  localparam ctr_t CTR_MAX   = 2'd3;
  localparam ctr_t CTR_MIN   = 2'd0;

  function automatic ctr_t ctr_train(ctr_t c, logic taken);
    if (taken) return (c == CTR_MAX) ? CTR_MAX : c + 2'd1;
    else       return (c == CTR_MIN) ? CTR_MIN : c - 2'd1;
  endfunction

  function automatic logic ctr_dir(ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/lhp_hist_table.sv
module lhp_hist_table #(
  parameter int IDX_W  = 5,
  parameter int HIST_W = 3,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [HIST_W-1:0] rd_hist_o,
  input  logic              upd_en_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  logic              upd_taken_i,
  output logic [HIST_W-1:0] upd_hist_o
);
  logic [HIST_W-1:0] hist_q [ENTRIES];
  logic [HIST_W-1:0] hist_next;

  assign rd_hist_o  = hist_q[rd_idx_i];
  assign upd_hist_o = hist_q[upd_idx_i];

  generate
    if (HIST_W == 1) begin : g_h1
      assign hist_next = upd_taken_i;
    end else begin : g_hn
      assign hist_next = {upd_hist_o[HIST_W-2:0], upd_taken_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) hist_q[i] <= '0;
    end else if (upd_en_i) begin
      hist_q[upd_idx_i] <= hist_next;
    end
  end

  // R7
  newest_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i |=> hist_q[$past(upd_idx_i)][0] == $past(upd_taken_i));

  generate
    if (HIST_W > 1) begin : g_shift_chk
      // R7
      shift_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_en_i |=> hist_q[$past(upd_idx_i)][1] == $past(upd_hist_o[0]));
    end
  endgenerate
endmodule

// File: rtl/lhp_ctr_bank.sv
module lhp_ctr_bank
  import lhp_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int HIST_W = 3,
  localparam int ADDR_W = IDX_W + HIST_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [HIST_W-1:0] rd_hist_i,
  output ctr_t              rd_cnt_o,
  input  logic              upd_en_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  logic [HIST_W-1:0] upd_hist_i,
  input  logic              upd_taken_i
);
  ctr_t              cnt_q [DEPTH];
  logic [ADDR_W-1:0] rd_addr, upd_addr;
  ctr_t              upd_old;

  assign rd_addr  = {rd_idx_i, rd_hist_i};
  assign upd_addr = {upd_idx_i, upd_hist_i};
  assign rd_cnt_o = cnt_q[rd_addr];
  assign upd_old  = cnt_q[upd_addr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= CTR_RESET;
    end else if (upd_en_i) begin
      cnt_q[upd_addr] <= ctr_train(upd_old, upd_taken_i);
    end
  end

  // R4
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i && upd_taken_i && upd_old != CTR_MAX
    |=> cnt_q[$past(upd_addr)] == $past(upd_old) + 2'd1);
  // R4
  inc_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i && upd_taken_i && upd_old == CTR_MAX
    |=> cnt_q[$past(upd_addr)] == CTR_MAX);
  // R5
  dec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i && !upd_taken_i && upd_old != CTR_MIN
    |=> cnt_q[$past(upd_addr)] == $past(upd_old) - 2'd1);
  // R5
  dec_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i && !upd_taken_i && upd_old == CTR_MIN
    |=> cnt_q[$past(upd_addr)] == CTR_MIN);
  // R9
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_en_i |=> $stable(cnt_q[rd_addr]) || rd_addr != $past(rd_addr));
endmodule

// File: rtl/lhp_predictor.sv
module lhp_predictor
  import lhp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 5,
  parameter int HIST_W = 3   // 1..4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lookup_pc_i,
  output logic            pred_taken_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i
);
  localparam int IDX_LSB = 2;  // 4-byte instruction alignment

  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [HIST_W-1:0] lk_hist, up_hist;
  ctr_t              lk_cnt;

  assign lk_idx = lookup_pc_i[IDX_W+IDX_LSB-1:IDX_LSB];
  assign up_idx = upd_pc_i[IDX_W+IDX_LSB-1:IDX_LSB];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{lookup_pc_i[IDX_LSB-1:0], lookup_pc_i[PC_W-1:IDX_W+IDX_LSB],
                            upd_pc_i[IDX_LSB-1:0], upd_pc_i[PC_W-1:IDX_W+IDX_LSB]};

  lhp_hist_table #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (lk_idx),
    .rd_hist_o  (lk_hist),
    .upd_en_i   (upd_valid_i),
    .upd_idx_i  (up_idx),
    .upd_taken_i(upd_taken_i),
    .upd_hist_o (up_hist)
  );

  lhp_ctr_bank #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (lk_idx),
    .rd_hist_i  (lk_hist),
    .rd_cnt_o   (lk_cnt),
    .upd_en_i   (upd_valid_i),
    .upd_idx_i  (up_idx),
    .upd_hist_i (up_hist),
    .upd_taken_i(upd_taken_i)
  );

  assign pred_taken_o = ctr_dir(lk_cnt);

  // R8
  other_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && up_idx != lk_idx |=> $past(lookup_pc_i) != lookup_pc_i
      || pred_taken_o == $past(pred_taken_o));
endmodule

// File: tb/tb_lhp_predictor.sv
module tb_lhp_predictor;
  localparam int PC_W = 32, IDX_W = 5, HIST_W = 3;
  localparam int NE = 1 << IDX_W, NH = 1 << HIST_W;

  logic clk_i = 0, rst_ni = 0;
  logic [PC_W-1:0] lookup_pc_i = '0, upd_pc_i = '0;
  logic upd_valid_i = 0, upd_taken_i = 0;
  logic pred_taken_o;

  lhp_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) dut (.*);

  always #10 clk_i = ~clk_i;  // 50 MHz

  int checks = 0, fails = 0;
  int m_hist [NE];
  int m_cnt  [NE][NH];

  // {outcome, expected prediction} for one branch at 0x40 from reset
  localparam logic [1:0] VEC [12] = '{2'b10, 2'b10, 2'b10, 2'b10, 2'b11, 2'b01,
                                      2'b00, 2'b10, 2'b01, 2'b00, 2'b11, 2'b10};

  function automatic int idx_of(logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  function automatic logic model_pred(logic [PC_W-1:0] pc);
    int e = idx_of(pc);
    return m_cnt[e][m_hist[e]] >= 2;
  endfunction

  task automatic check(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: pred_taken_o=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update(logic [PC_W-1:0] pc, logic t);
    int e = idx_of(pc);
    int h = m_hist[e];
    if (t) m_cnt[e][h] = (m_cnt[e][h] == 3) ? 3 : m_cnt[e][h] + 1;
    else   m_cnt[e][h] = (m_cnt[e][h] == 0) ? 0 : m_cnt[e][h] - 1;
    m_hist[e] = ((h << 1) | int'(t)) & (NH - 1);
  endtask

  task automatic look(logic [PC_W-1:0] pc, logic exp, string tag);
    @(negedge clk_i);
    lookup_pc_i = pc;
    #2 check(pred_taken_o, exp, tag);
  endtask

  // lookup then update of the same branch; lookup checked against the model
  task automatic step(logic [PC_W-1:0] pc, logic t, string tag);
    @(negedge clk_i);
    lookup_pc_i = pc;
    #2 check(pred_taken_o, model_pred(pc), tag);
    upd_valid_i = 1; upd_pc_i = pc; upd_taken_i = t;
    @(posedge clk_i);
    #1 upd_valid_i = 0;
    model_update(pc, t);
  endtask

  task automatic update_only(logic [PC_W-1:0] pc, logic t);
    @(negedge clk_i);
    upd_valid_i = 1; upd_pc_i = pc; upd_taken_i = t;
    @(posedge clk_i);
    #1 upd_valid_i = 0;
    model_update(pc, t);
  endtask

  initial begin
    #(20ns * 200000);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int e = 0; e < NE; e++) begin
      m_hist[e] = 0;
      for (int h = 0; h < NH; h++) m_cnt[e][h] = 1;
    end
    #35 rst_ni = 1;

    // R2: reset state predicts not taken everywhere
    look(32'h0000_0040, 1'b0, "R2");
    look(32'h0000_007C, 1'b0, "R2");
    look(32'hFFFF_FF00, 1'b0, "R2");

    // R3 R4 R5 R6 R7: vector walk on one branch
    for (int i = 0; i < 12; i++) begin
      @(negedge clk_i);
      lookup_pc_i = 32'h0000_0040;
      #2 check(pred_taken_o, VEC[i][0], "R6 vector");
      check(pred_taken_o, model_pred(32'h40), "R3 model");
      upd_valid_i = 1; upd_pc_i = 32'h40; upd_taken_i = VEC[i][1];
      @(posedge clk_i);
      #1 upd_valid_i = 0;
      model_update(32'h40, VEC[i][1]);
    end

    // R8: other index untouched; aliased address shares the entry
    look(32'h0000_0044, 1'b0, "R8 untouched");
    look(32'h0000_00C0, model_pred(32'h40), "R8 alias");
    // R1: byte-offset bits and high bits ignored
    look(32'h0000_0043, model_pred(32'h40), "R1 low bits");
    look(32'hABC0_0040, model_pred(32'h40), "R1 high bits");

    // R5: floor at 0 on entry 5 (pc 0x14), history stays 000
    update_only(32'h14, 1'b0);
    update_only(32'h14, 1'b0);
    update_only(32'h14, 1'b0);
    update_only(32'h14, 1'b1);              // cnt[000] 0->1, hist 001
    update_only(32'h14, 1'b0);
    update_only(32'h14, 1'b0);
    update_only(32'h14, 1'b0);              // hist back to 000
    look(32'h14, 1'b0, "R5 floor");
    update_only(32'h14, 1'b1);              // cnt[000] 1->2
    update_only(32'h14, 1'b0);
    update_only(32'h14, 1'b0);
    update_only(32'h14, 1'b0);
    look(32'h14, 1'b1, "R5 step up after floor");

    // R4: ceiling at 3 with always-taken branch at 0x30
    for (int i = 0; i < 8; i++) update_only(32'h30, 1'b1);
    step(32'h30, 1'b0, "R4 ceiling");
    look(32'h30, model_pred(32'h30), "R4 after one not-taken");

    // R9: same-cycle lookup and update on entry 3 (pc 0x0C)
    update_only(32'h0C, 1'b1);
    update_only(32'h0C, 1'b0);
    update_only(32'h0C, 1'b0);
    update_only(32'h0C, 1'b0);              // hist 000, cnt[000]=2
    @(negedge clk_i);
    lookup_pc_i = 32'h0C;
    upd_valid_i = 1; upd_pc_i = 32'h0C; upd_taken_i = 1'b0;
    #2 check(pred_taken_o, 1'b1, "R9 pre-update value");
    @(posedge clk_i);
    #1 upd_valid_i = 0;
    model_update(32'h0C, 1'b0);
    look(32'h0C, 1'b0, "R9 post-update value");

    // R10: learn (0011)* on pc 0x20
    for (int p = 0; p < 4; p++) begin
      update_only(32'h20, 1'b0); update_only(32'h20, 1'b0);
      update_only(32'h20, 1'b1); update_only(32'h20, 1'b1);
    end
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 4; k++) begin
        logic t;
        t = (k >= 2);
        @(negedge clk_i);
        lookup_pc_i = 32'h20;
        #2 check(pred_taken_o, t, "R10 pattern");
        upd_valid_i = 1; upd_pc_i = 32'h20; upd_taken_i = t;
        @(posedge clk_i);
        #1 upd_valid_i = 0;
        model_update(32'h20, t);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule